// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is an I2C bus master that software steers one byte at a time. A host writes a command word, and the engine carries out the bus actions that word asks for. Each word can combine any of these actions: a START condition, one byte sent with the slave's acknowledge checked, one byte received with ACK or NACK returned, and a STOP condition. When the engine finishes a command it clears the command register and raises a completion flag. Seven event flags drive a single level interrupt, and each flag has its own mask bit and its own write-one-to-clear bit. Only 7-bit addressing is supported. The address byte is written to the transmit register as `addr<<1 | rw`.

The host sees eight 32-bit registers. `reg_idx` selects one, and its byte offset is `reg_idx*4`:
- 0 is control.
- 1 is command.
- 2 is flag clear.
- 3 is status.
- 4 is the SCL high count.
- 5 is the SCL low count.
- 6 is transmit data.
- 7 is receive data.

Both bus lines are open-drain. An output-enable of 1 pulls the line low. The engine drives SCL low between commands for as long as it owns the bus. It does not support clock stretching by the slave.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, status and control read as 0, and `scl_oe`, `sda_oe` and `irq` are all 0.
- R2: The following registers read back what was written, with unused upper bits reading 0:
  - control, 9 bits: bit 8 is enable, bit 7 is the global interrupt unmask, and bits 6..0 are per-flag masks.
  - SCL high count and SCL low count, CNT_W bits each.
  - transmit data, 8 bits.
- R3: Command bit 3 (START) produces a falling SDA while SCL is released. It sets status bit 7 (bus owned) and status bit 6 (start done).
- R4: Command bit 1 (WRITE) shifts out the transmit byte MSB first, then releases SDA for the ninth clock. If the slave acknowledges, status bit 4 (byte sent) is set.
- R5: If SDA is high on the ninth clock of a WRITE, the engine sets status bit 2 (no acknowledge) and ends the command. A STOP requested in the same word is skipped, and bus ownership (bit 7) stays set.
- R6: Command bit 2 (READ) shifts one byte, MSB first, into the receive register. On the ninth clock the engine drives SDA low (ACK), or releases it when command bit 4 (NACK) is also set. Status bit 3 (byte received) is set.
- R7: Command bit 0 (STOP) produces a rising SDA while SCL is released. It sets status bit 5 (stop done), clears status bit 7, and releases both lines.
- R8: When START, WRITE and STOP are set together, the engine performs them in that order within one command.
- R9: Every SCL low phase lasts 2*(L+1) clocks and every SCL high phase lasts 2*(H+1) clocks, where L and H are the low and high count registers.
- R10: If SDA reads low at the end of a high phase while the engine is sending a 1 data bit, arbitration is lost. The engine sets status bit 1, ends the command, clears bit 7, and releases both lines.
- R11: Writing 1 to a bit in 6..0 of the clear register clears that status flag. Writing 0 leaves the flag unchanged, and status bit 7 is not affected.
- R12: `irq` is high exactly when enable (bit 8), global unmask (bit 7) and at least one flag with its mask bit set are all present.
- R13: When any command ends, the engine sets status bit 0 (command complete) and the command register reads 0. A command write made while a command is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_idx` |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps all 256 byte values through both WRITE and READ, so a reversed shift order or an off-by-one bit counter shows up as a wrong byte on the bus or in the receive register. It sweeps four high and four low counts and measures each phase in clocks. A timer that lost its doubling or its +1 reports a short phase. For a combined START+WRITE+STOP word, the order of bus events on the wire is logged, so a STOP issued early or a START issued late is caught. It forces a slave NACK and a jammed SDA, because a design that continued into the STOP after a NACK, or kept SCL owned after losing arbitration, would leave the wrong flags or a held line. It also walks every mask pattern against a fixed flag set with the global unmask both off and on.

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        irq
);
  localparam int TW = CNT_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_STA0, S_STA1, S_STA2, S_BLO, S_BHI, S_SP0, S_SP1, S_SP2
  } st_t;

  st_t st, nxt;
  logic [8:0]       ctrl;
  logic [4:0]       cmd;
  logic [6:0]       flags, ev;
  logic             busy, fin, bset, bclr, want, sda_q;
  logic [CNT_W-1:0] hcnt, lcnt;
  logic [7:0]       txd, rxd, sh;
  logic [3:0]       bitn;
  logic [TW-1:0]    tmr;
  logic             unused_hi;

  assign unused_hi = ^reg_wdata[31:CNT_W];

  wire tick    = (tmr == '0);
  wire w_ctl   = reg_we && reg_idx == 3'd0;
  wire w_cmd   = reg_we && reg_idx == 3'd1;
  wire w_icr   = reg_we && reg_idx == 3'd2;
  wire wr_op   = cmd[1];
  wire data_op = cmd[1] | cmd[2];
  wire last_b  = (bitn == 4'd8);
  wire nhi     = nxt inside {S_STA1, S_STA2, S_BHI, S_SP1, S_SP2};
  wire [6:0] clr = w_icr ? reg_wdata[6:0] : 7'd0;

  always_comb begin
    nxt = st; ev = '0; fin = 1'b0; bset = 1'b0; bclr = 1'b0; want = 1'b0;
    case (st)
      S_IDLE: if (ctrl[8] && cmd != 5'd0) begin
        if (cmd[3])       nxt = S_STA0;
        else if (data_op) nxt = S_BLO;
        else if (cmd[0])  nxt = S_SP0;
        else              fin = 1'b1;
      end
      S_STA0: if (tick) nxt = S_STA1;
      S_STA1: if (tick) begin nxt = S_STA2; bset = 1'b1; end
      S_STA2: begin
        want = 1'b1;
        if (tick) begin
          ev[6] = 1'b1;
          if (data_op)     nxt = S_BLO;
          else if (cmd[0]) nxt = S_SP0;
          else begin nxt = S_IDLE; fin = 1'b1; end
        end
      end
      S_BLO, S_BHI: begin
        want = last_b ? (!wr_op && !cmd[4]) : (wr_op && !sh[7]);
        if (st == S_BLO) begin
          if (tick) nxt = S_BHI;
        end else if (tick) begin
          if (wr_op && !last_b && sh[7] && !sda_in) begin
            ev[1] = 1'b1; nxt = S_IDLE; fin = 1'b1; bclr = 1'b1;
          end else if (!last_b) begin
            nxt = S_BLO;
          end else if (wr_op && sda_in) begin
            ev[2] = 1'b1; nxt = S_IDLE; fin = 1'b1;
          end else begin
            ev[4] = wr_op; ev[3] = !wr_op;
            if (cmd[0]) nxt = S_SP0;
            else begin nxt = S_IDLE; fin = 1'b1; end
          end
        end
      end
      S_SP0: begin want = 1'b1; if (tick) nxt = S_SP1; end
      S_SP1: begin want = 1'b1; if (tick) nxt = S_SP2; end
      S_SP2: if (tick) begin ev[5] = 1'b1; bclr = 1'b1; nxt = S_IDLE; fin = 1'b1; end
      default: nxt = S_IDLE;
    endcase
    ev[0] = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; bitn <= '0; sh <= '0; rxd <= '0; sda_q <= 1'b0;
      ctrl <= '0; cmd <= '0; flags <= '0; busy <= 1'b0;
      hcnt <= '0; lcnt <= '0; txd <= '0;
    end else begin
      st    <= nxt;
      sda_q <= want;
      flags <= (flags & ~clr) | ev;
      if (nxt != st)   tmr <= nhi ? {hcnt, 1'b1} : {lcnt, 1'b1};
      else if (!tick)  tmr <= tmr - 1'b1;
      if (st != S_BLO && st != S_BHI && nxt == S_BLO) begin
        bitn <= '0;
        sh   <= wr_op ? txd : 8'h00;
      end else if (st == S_BHI && tick) begin
        bitn <= bitn + 1'b1;
        sh   <= {sh[6:0], sda_in};
        if (bitn == 4'd7 && !wr_op) rxd <= {sh[6:0], sda_in};
      end
      if (bset)      busy <= 1'b1;
      else if (bclr) busy <= 1'b0;
      if (fin)                        cmd <= '0;
      else if (w_cmd && cmd == 5'd0)  cmd <= reg_wdata[4:0];
      if (w_ctl) ctrl <= reg_wdata[8:0];
      if (reg_we && reg_idx == 3'd4) hcnt <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_idx == 3'd5) lcnt <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_idx == 3'd6) txd  <= reg_wdata[7:0];
    end
  end

  always_comb begin
    case (reg_idx)
      3'd0:    reg_rdata = {23'd0, ctrl};
      3'd1:    reg_rdata = {27'd0, cmd};
      3'd2:    reg_rdata = 32'd0;
      3'd3:    reg_rdata = {24'd0, busy, flags};
      3'd4:    reg_rdata = 32'(hcnt);
      3'd5:    reg_rdata = 32'(lcnt);
      3'd6:    reg_rdata = {24'd0, txd};
      default: reg_rdata = {24'd0, rxd};
    endcase
  end

  assign scl_oe = (st == S_IDLE) ? busy : (st == S_STA0 || st == S_BLO || st == S_SP0);
  assign sda_oe = sda_q;
  assign irq    = ctrl[8] & ctrl[7] & (|(flags & ctrl[6:0]));

  a_r13_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 5'd0 && st != S_IDLE) |=> (cmd == $past(cmd) || cmd == 5'd0));
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icr && ev == 7'd0) |=> ((flags & $past(reg_wdata[6:0])) == 7'd0));
  a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> st == S_STA2);
  a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> st == S_SP2);
  a_r6_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BHI && last_b && !wr_op) |-> sda_oe == !cmd[4]);
  a_r10_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BHI && tick && ev[1]) |=> (!busy && !scl_oe && st == S_IDLE));
endmodule

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  logic clk = 0, rst_n = 0, we = 0;
  logic [2:0] idx = 0;
  logic [31:0] wd = 0, v;
  wire [31:0] rd;
  wire scl_oe, sda_oe, irq;
  logic s_drv = 0;
  wire sda_line = !(sda_oe || s_drv);
  wire scl_line = !scl_oe;

  i2c_cmd_master dut(.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_idx(idx), .reg_wdata(wd),
    .reg_rdata(rd), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int rise_n = 0, mode = 0, starts = 0, stops = 0, low_cyc = 0, high_cyc = 0;
  logic [7:0] s_byte = 0, m_byte = 0, m_last = 0;
  logic m_ack = 0;
  logic [31:0] evs = 0;
  time t_fall = 0, t_rise = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic drv();
    case (mode)
      1: return rise_n == 8;
      3: return rise_n < 8 && !s_byte[7 - rise_n];
      4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge scl_line) begin
    s_drv = drv(); t_fall = $time; high_cyc = int'((t_fall - t_rise) / 4);
  end
  always @(posedge scl_line) begin
    t_rise = $time; low_cyc = int'((t_rise - t_fall) / 4);
    if (rise_n < 8) m_byte = {m_byte[6:0], sda_line};
    else begin
      m_ack = sda_line; m_last = m_byte; evs = {evs[27:0], 4'h2};
      if (mode == 3 && sda_line) mode = 0;
    end
    rise_n = (rise_n == 8) ? 0 : rise_n + 1;
  end
  always @(negedge sda_line) if (scl_line) begin starts++; rise_n = 0; evs = {evs[27:0], 4'h1}; end
  always @(posedge sda_line) if (scl_line) begin stops++; evs = {evs[27:0], 4'h3}; end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic arm(); s_drv = drv(); endtask
  task automatic wreg(input int i, input logic [31:0] d);
    @(negedge clk); we = 1; idx = i[2:0]; wd = d;
    @(negedge clk); we = 0;
  endtask
  task automatic rreg(input int i, output logic [31:0] d);
    @(negedge clk); idx = i[2:0]; #1 d = rd;
  endtask
  task automatic waitd(input string req, output logic [31:0] s);
    s = 0;
    for (int k = 0; k < 3000; k++) begin rreg(3, s); if (s[0]) break; end
    if (!s[0]) chk({req, " completion"}, s, s | 32'h1);
  endtask
  task automatic run(input string req, input logic [4:0] c, output logic [31:0] s);
    wreg(2, 32'h7F); wreg(1, {27'd0, c}); waitd(req, s);
  endtask

  initial begin
    int st0, sp0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rreg(3, v); chk("R1 status", v, 0);
    rreg(0, v); chk("R1 control", v, 0);
    chk("R1 lines+irq", {scl_oe, sda_oe, irq}, 0);

    wreg(0, 32'hFFFF_F1FF); rreg(0, v); chk("R2 control", v, 32'h1FF);
    wreg(4, 32'hABCD_1234); rreg(4, v); chk("R2 high count", v, 32'h1234);
    wreg(5, 32'h0000_8765); rreg(5, v); chk("R2 low count", v, 32'h8765);
    wreg(6, 32'h3C5);       rreg(6, v); chk("R2 tx", v, 32'hC5);
    wreg(0, 32'h100); wreg(4, 1); wreg(5, 1);

    st0 = starts;
    run("R3", 5'h08, v);
    chk("R3 status", v, 32'hC1);
    chk("R3 start seen", starts - st0, 1);
    rreg(1, v); chk("R13 cmd cleared", v, 0);
    chk("R3 scl held", {scl_oe, sda_oe}, 2'b10);
    wreg(2, 32'h40); rreg(3, v); chk("R11 partial clear", v, 32'h81);
    wreg(2, 32'h7F); rreg(3, v); chk("R11 busy kept", v, 32'h80);

    mode = 1; arm();
    for (int b = 0; b < 256; b++) begin
      wreg(6, b); run("R4", 5'h02, v);
      chk("R4 byte on bus", m_last, b);
      chk("R4 slave ack", m_ack, 0);
      chk("R4 status", v, 32'h91);
    end

    sp0 = stops;
    wreg(2, 32'h7F); wreg(6, 32'h55); wreg(1, 32'h02); wreg(1, 32'h01);
    rreg(1, v); chk("R13 pending kept", v, 32'h02);
    waitd("R13", v);
    chk("R13 status", v, 32'h91);
    chk("R13 no stop", stops - sp0, 0);
    chk("R13 byte", m_last, 32'h55);

    mode = 3;
    for (int b = 0; b < 256; b++) begin
      s_byte = b; arm(); run("R6", 5'h04, v);
      rreg(7, v); chk("R6 rx", v, b);
      chk("R6 master ack", m_ack, 0);
      rreg(3, v); chk("R6 status", v, 32'h89);
    end
    s_byte = 8'hA7; arm(); run("R6", 5'h14, v);
    chk("R6 nack status", v, 32'h89);
    rreg(7, v); chk("R6 rx last", v, 32'hA7);
    chk("R6 master nack", m_ack, 1);

    mode = 0; arm(); sp0 = stops;
    run("R7", 5'h01, v);
    chk("R7 status", v, 32'h21);
    chk("R7 stop seen", stops - sp0, 1);
    chk("R7 lines released", {scl_oe, sda_oe}, 0);

    mode = 1; arm(); st0 = starts; sp0 = stops; evs = 0;
    wreg(6, 32'h91); run("R8", 5'h0B, v);
    chk("R8 status", v, 32'h71);
    chk("R8 order", evs[11:0], 32'h123);
    chk("R8 byte", m_last, 32'h91);
    chk("R8 start/stop", {starts - st0, stops - sp0}, {32'd1, 32'd1});

    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 128; m++) begin
        wreg(0, 32'h100 | (g << 7) | m);
        chk("R12 irq", irq, (g == 1) && ((m & 32'h71) != 0));
      end
    wreg(0, 32'h0FF); chk("R12 disabled", irq, 0);
    wreg(0, 32'h100);

    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++) begin
        wreg(4, h); wreg(5, l); wreg(6, 32'hA0 + h * 4 + l);
        run("R9", 5'h0B, v);
        chk("R9 low phase", low_cyc, 2 * (l + 1));
        chk("R9 high phase", high_cyc, 2 * (h + 1));
        chk("R9 status", v, 32'h71);
      end
    wreg(4, 1); wreg(5, 1);

    mode = 2; arm(); sp0 = stops;
    wreg(6, 32'h90); run("R5", 5'h0B, v);
    chk("R5 status", v, 32'hC5);
    chk("R5 stop skipped", stops - sp0, 0);
    chk("R5 scl held", scl_oe, 1);
    mode = 0; arm(); run("R7", 5'h01, v); chk("R7 recovery", v, 32'h21);

    run("R10", 5'h08, v); chk("R10 start", v, 32'hC1);
    mode = 4; arm();
    wreg(6, 32'hFF); run("R10", 5'h02, v);
    chk("R10 status", v, 32'h03);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);
    rreg(1, v); chk("R10 cmd cleared", v, 0);
    mode = 0; arm();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule